// File: doc/BRIEF.md
# Width-Flexible FIFO Data Port

This block is the host-side access point for a byte-wide transmit queue and a byte-wide receive queue. A single host access moves 1, 2, 3 or 4 bytes. The number of enabled byte lanes sets the width of the access, and the queue pointer advances by the number of bytes actually moved. Each queue holds 64 entries and reports its fill level.

The receive queue stores an 8-bit data byte and a 3-bit line-status error code per entry. There are two host locations. The data location gives plain bytes. The paired location returns each byte next to its own error code, so data and status cannot drift apart. Because of this, the paired location accepts only 16-bit and 32-bit reads.

The line side of each queue is a valid/ready stream.
- The transmit stream presents the oldest byte while `tx_out_valid` is high. The byte leaves on a cycle with `tx_out_valid && tx_out_ready`.
- The receive stream takes a byte on a cycle with `rx_in_valid && rx_in_ready`. `rx_in_ready` drops only when the receive queue is full.

The host side has no back-pressure. Every host access completes in the cycle it is presented. Read data appears on the next cycle, flagged by `host_rvalid`.

Top module: `fifo_data_port`

## Requirements
- R1: After reset both levels are 0, and `host_rvalid`, `acc_err`, `tx_ovf` and `tx_out_valid` are 0.
- R2: A host write to location 0 (`host_addr`=0) with n byte enables set pushes n bytes into the transmit queue, lane 0 (bits 7:0) first and then upward. The transmit level rises by n on the next cycle.
- R3: `tx_out_valid` is high exactly when the transmit queue is non-empty, and `tx_out_data` is its oldest byte. One byte leaves on each cycle with valid and ready both high.
- R4: A host read of location 0 with n enables pops n receive entries in arrival order. The k-th byte appears in lane k (bits 8k+7:8k) of `host_rdata` on the next cycle, with `host_rvalid` high.
- R5: When a read asks for more entries than the receive queue holds, only the held entries are popped. The remaining lanes read as zero.
- R6: A read of location 1 with 2 enables pops one entry, and a read with 4 enables pops up to two entries. Each 16-bit half is laid out as {5'b0, err[2:0], data[7:0]}, with the older entry in bits 15:0. Halves with no entry read as zero.
- R7: A read of location 1 with any enable count other than 2 or 4 returns zero data and pops nothing. It also raises `acc_err` for one cycle, alongside the read data.
- R8: When a write carries more bytes than the transmit queue has free, the bytes that fit are kept and the excess is discarded. `tx_ovf` pulses on the next cycle. Free space is measured before any pop in the same cycle, and the level never exceeds 64.
- R9: `rx_in_ready` is high exactly when the receive queue holds fewer than 64 entries. An accepted entry raises the level by one, net of host pops in the same cycle.
- R10: A host write to location 1 changes neither queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access present this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 1 | 0 = data location, 1 = paired data/status location |
| host_be | input | 4 | Byte lane enables; the count sets the width |
| host_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| host_rvalid | output | 1 | Read data valid (one cycle after the read) |
| host_rdata | output | 32 | Read data |
| acc_err | output | 1 | Pulse: illegal width on the paired location |
| tx_ovf | output | 1 | Pulse: write bytes discarded for lack of space |
| tx_out_valid | output | 1 | Transmit stream valid |
| tx_out_ready | input | 1 | Transmit stream ready |
| tx_out_data | output | 8 | Transmit stream byte |
| rx_in_valid | input | 1 | Receive stream valid |
| rx_in_ready | output | 1 | Receive stream ready |
| rx_in_data | input | 8 | Receive stream byte |
| rx_in_err | input | 3 | Receive stream error code |
| tx_level | output | 7 | Transmit queue fill level |
| rx_level | output | 7 | Receive queue fill level |

## Verification
The bench mixes all four widths on both locations with random line-side valid and ready. This separates a pointer that advances by access width from one that advances by a fixed step, and shows whether lane ordering holds across the queue's wrap point.

Directed runs cover three edge cases:
- Filling the transmit queue, then writing 4 bytes into one free slot. This separates clipping by free space from whole-access rejection.
- Wide reads of a nearly empty receive queue. These show whether the short-pop lanes are zeroed and whether the level drops only by the entries held.
- Reads of the paired location at odd widths, against entries with distinct error codes. These tell a misaligned pair from a correct one, and an illegal access that pops from one that leaves the queue unchanged.

// File: rtl/fifo_dp_pkg.sv
package fifo_dp_pkg;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 3;
  localparam int ENT_W  = DATA_W + ERR_W;
  localparam int LANES  = 4;
  localparam int PAIR_W = 16;

  typedef enum logic {
    LOC_DATA   = 1'b0,
    LOC_PAIRED = 1'b1
  } loc_e;
endpackage

// File: rtl/fdp_mlane_fifo.sv
module fdp_mlane_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  parameter int NP    = 4,
  parameter int NQ    = 1,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(NP + 1),
  localparam int QW   = $clog2(NQ + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PW-1:0]         push_n,
  input  logic [NP-1:0][W-1:0]  push_data,
  input  logic [QW-1:0]         pop_n,
  output logic [NQ-1:0][W-1:0]  pop_data,
  output logic [LW-1:0]         level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop_n);
      cnt    <= cnt + LW'(push_n) - LW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NP; i++) begin
      if (i < int'(push_n)) mem[wr_ptr + AW'(i)] <= push_data[i];
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_rd
    assign pop_data[q] = mem[rd_ptr + AW'(q)];
  end

  assign level = cnt;
endmodule

// File: rtl/fdp_decode.sv
module fdp_decode #(
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          host_valid,
  input  logic          host_write,
  input  logic          host_addr,
  input  logic [3:0]    host_be,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  output logic [2:0]    tx_push_n,
  output logic [2:0]    rx_pop_n,
  output logic          paired_rd,
  output logic          bad_rd,
  output logic          ovf
);
  import fifo_dp_pkg::*;

  logic [2:0]    nb;
  logic [2:0]    want;
  logic [LW-1:0] tx_free;

  always_comb begin
    nb        = 3'($countones(host_be));
    tx_free   = LW'(DEPTH) - tx_level;
    tx_push_n = '0;
    rx_pop_n  = '0;
    paired_rd = 1'b0;
    bad_rd    = 1'b0;
    ovf       = 1'b0;
    want      = '0;
    if (host_valid && host_write && loc_e'(host_addr) == LOC_DATA) begin
      if (LW'(nb) > tx_free) begin
        tx_push_n = 3'(tx_free);
        ovf       = 1'b1;
      end else begin
        tx_push_n = nb;
      end
    end else if (host_valid && !host_write) begin
      if (loc_e'(host_addr) == LOC_PAIRED) begin
        paired_rd = 1'b1;
        if (nb == 3'd2 || nb == 3'd4) want = nb >> 1;
        else bad_rd = 1'b1;
      end else begin
        want = nb;
      end
      rx_pop_n = (LW'(want) > rx_level) ? 3'(rx_level) : want;
    end
  end
endmodule

// File: rtl/fifo_data_port.sv
module fifo_data_port #(
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  input  logic          host_write,
  input  logic          host_addr,
  input  logic [3:0]    host_be,
  input  logic [31:0]   host_wdata,
  output logic          host_rvalid,
  output logic [31:0]   host_rdata,
  output logic          acc_err,
  output logic          tx_ovf,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [7:0]    tx_out_data,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [7:0]    rx_in_data,
  input  logic [2:0]    rx_in_err,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level
);
  import fifo_dp_pkg::*;

  logic [2:0] tx_push_n, rx_pop_n;
  logic       paired_rd, bad_rd, ovf;
  logic [LANES-1:0][DATA_W-1:0] wbytes;
  logic [0:0][DATA_W-1:0]       tx_head;
  logic [LANES-1:0][ENT_W-1:0]  rx_head;
  logic [0:0][ENT_W-1:0]        rx_push;
  logic [31:0]                  rd_next;
  logic                         tx_take, rx_take;

  assign wbytes  = host_wdata;
  assign rx_push = {rx_in_err, rx_in_data};

  fdp_decode #(.DEPTH(DEPTH)) u_dec (
    .host_valid (host_valid),
    .host_write (host_write),
    .host_addr  (host_addr),
    .host_be    (host_be),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .tx_push_n  (tx_push_n),
    .rx_pop_n   (rx_pop_n),
    .paired_rd  (paired_rd),
    .bad_rd     (bad_rd),
    .ovf        (ovf)
  );

  assign tx_out_valid = (tx_level != '0);
  assign tx_take      = tx_out_valid && tx_out_ready;
  assign tx_out_data  = tx_head[0];

  fdp_mlane_fifo #(.W(DATA_W), .DEPTH(DEPTH), .NP(LANES), .NQ(1)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_n    (tx_push_n),
    .push_data (wbytes),
    .pop_n     (tx_take),
    .pop_data  (tx_head),
    .level     (tx_level)
  );

  assign rx_in_ready = (rx_level != LW'(DEPTH));
  assign rx_take     = rx_in_valid && rx_in_ready;

  fdp_mlane_fifo #(.W(ENT_W), .DEPTH(DEPTH), .NP(1), .NQ(LANES)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_n    (rx_take),
    .push_data (rx_push),
    .pop_n     (rx_pop_n),
    .pop_data  (rx_head),
    .level     (rx_level)
  );

  always_comb begin
    rd_next = '0;
    if (paired_rd) begin
      for (int j = 0; j < LANES / 2; j++) begin
        if (j < int'(rx_pop_n)) rd_next[j*PAIR_W +: PAIR_W] = PAIR_W'(rx_head[j]);
      end
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (i < int'(rx_pop_n)) rd_next[i*DATA_W +: DATA_W] = rx_head[i][DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
      acc_err     <= 1'b0;
      tx_ovf      <= 1'b0;
    end else begin
      host_rvalid <= host_valid && !host_write;
      host_rdata  <= rd_next;
      acc_err     <= bad_rd;
      tx_ovf      <= ovf;
    end
  end
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_valid,
  input logic          host_write,
  input logic          host_addr,
  input logic [3:0]    host_be,
  input logic [31:0]   host_wdata,
  input logic          host_rvalid,
  input logic [31:0]   host_rdata,
  input logic          acc_err,
  input logic          tx_ovf,
  input logic          tx_out_valid,
  input logic          tx_out_ready,
  input logic [7:0]    tx_out_data,
  input logic          rx_in_valid,
  input logic          rx_in_ready,
  input logic [7:0]    rx_in_data,
  input logic [2:0]    rx_in_err,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level
);
  logic host_rd, host_wr0, odd_pair;
  assign host_rd  = host_valid && !host_write;
  assign host_wr0 = host_valid && host_write && !host_addr;
  assign odd_pair = host_rd && host_addr &&
                    !($countones(host_be) == 2 || $countones(host_be) == 4);

  AST_TX_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(DEPTH)); // R8
  AST_RX_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH)); // R9
  AST_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid); // R4
  AST_TX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && tx_out_ready && !host_wr0) |=> tx_level == $past(tx_level) - 1); // R3
  AST_ODD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    odd_pair |=> acc_err && host_rdata == 32'd0 && rx_level >= $past(rx_level)); // R7
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |-> tx_level >= LW'(DEPTH - 1)); // R8
  AST_PAIR_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr) |=> host_rdata[15:11] == 5'd0 && host_rdata[31:27] == 5'd0); // R6
  AST_RX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_in_ready && !host_rd) |=> rx_level == $past(rx_level) + 1); // R9
endmodule

bind fifo_data_port fdp_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_fifo_data_port.sv
module sim_fifo_data_port;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_valid = 0, host_write = 0, host_addr = 0;
  logic [3:0] host_be = 0;
  logic [31:0] host_wdata = 0;
  logic host_rvalid, acc_err, tx_ovf, tx_out_valid, rx_in_ready;
  logic [31:0] host_rdata;
  logic tx_out_ready = 0, rx_in_valid = 0;
  logic [7:0] tx_out_data, rx_in_data = 0;
  logic [2:0] rx_in_err = 0;
  logic [6:0] tx_level, rx_level;

  int checks = 0, errors = 0;
  logic [7:0]  txq[$];
  logic [10:0] rxq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_data_port #(.DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic op(input bit hv, input bit wr, input bit ad, input logic [3:0] be,
                    input logic [31:0] wd, input bit txr, input bit rxv,
                    input logic [7:0] rd, input logic [2:0] re);
    int nb, txp, rxp, n;
    logic [31:0] erd;
    bit eerr, eovf, erv;
    string tg;
    @(negedge clk);
    host_valid = hv; host_write = wr; host_addr = ad; host_be = be; host_wdata = wd;
    tx_out_ready = txr; rx_in_valid = rxv; rx_in_data = rd; rx_in_err = re;
    #1;
    txp = txq.size(); rxp = rxq.size();
    chk(tx_out_valid == (txp != 0), "R3 valid", {31'd0, tx_out_valid}, {31'd0, txp != 0});
    if (txp != 0) chk(tx_out_data == txq[0], "R3 data", {24'd0, tx_out_data}, {24'd0, txq[0]});
    chk(rx_in_ready == (rxp < DEPTH), "R9 ready", {31'd0, rx_in_ready}, {31'd0, rxp < DEPTH});
    nb = $countones(be);
    erd = 0; eerr = 0; eovf = 0; erv = hv && !wr; tg = "R4";
    if (txp != 0 && txr) void'(txq.pop_front());
    if (hv && wr && !ad) begin
      n = min2(nb, DEPTH - txp);
      eovf = nb > DEPTH - txp;
      for (int k = 0; k < n; k++) txq.push_back(wd[8*k +: 8]);
    end else if (hv && !wr && !ad) begin
      n = min2(nb, rxp);
      if (nb > rxp) tg = "R5";
      for (int k = 0; k < n; k++) erd[8*k +: 8] = rxq.pop_front()[7:0];
    end else if (hv && !wr && ad) begin
      if (nb == 2 || nb == 4) begin
        tg = (nb / 2 > rxp) ? "R5/R6" : "R6";
        n = min2(nb / 2, rxp);
        for (int k = 0; k < n; k++) erd[16*k +: 16] = {5'd0, rxq.pop_front()};
      end else begin
        eerr = 1; tg = "R7";
      end
    end
    if (rxv && rxp < DEPTH) rxq.push_back({re, rd});
    @(posedge clk); #1;
    chk(host_rvalid == erv, "R4 rvalid", {31'd0, host_rvalid}, {31'd0, erv});
    if (erv) chk(host_rdata == erd, tg, host_rdata, erd);
    chk(acc_err == eerr, "R7 acc_err", {31'd0, acc_err}, {31'd0, eerr});
    chk(tx_ovf == eovf, "R8 tx_ovf", {31'd0, tx_ovf}, {31'd0, eovf});
    chk(int'(tx_level) == txq.size(), "R2 tx_level", {25'd0, tx_level}, txq.size());
    chk(int'(rx_level) == rxq.size(), "R9 rx_level", {25'd0, rx_level}, rxq.size());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] be_set[4] = '{4'h1, 4'h3, 4'h7, 4'hF};
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 2 + 2);
    // R1: reset state
    chk(tx_level == 0 && rx_level == 0, "R1 levels", {18'd0, tx_level, rx_level}, 0);
    chk(!host_rvalid && !acc_err && !tx_ovf && !tx_out_valid, "R1 flags",
        {28'd0, host_rvalid, acc_err, tx_ovf, tx_out_valid}, 0);
    rst_n = 1'b1;
    // R2/R8: fill transmit queue with 32-bit writes, then overflow
    for (int i = 0; i < 17; i++) op(1, 1, 0, 4'hF, $urandom, 0, 0, 0, 0);
    op(1, 1, 0, 4'h7, 32'h00ABCDEF, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 1, 0, 0, 0);
    op(1, 1, 0, 4'hF, 32'h44332211, 0, 0, 0, 0);  // R8 one byte kept
    for (int i = 0; i < 70; i++) op(0, 0, 0, 0, 0, 1, 0, 0, 0); // R3 drain
    // R10: write to paired location ignored
    op(1, 1, 1, 4'hF, 32'hDEADBEEF, 0, 0, 0, 0);
    // R5: short pops
    for (int i = 0; i < 3; i++) op(0, 0, 0, 0, 0, 0, 1, 8'(8'h10 + i), 3'(i + 1));
    op(1, 0, 0, 4'hF, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) op(0, 0, 0, 0, 0, 0, 1, 8'(8'hA0 + i), 3'(7 - i));
    // R7: odd widths on paired location
    op(1, 0, 1, 4'h1, 0, 0, 0, 0, 0);
    op(1, 0, 1, 4'h7, 0, 0, 0, 0, 0);
    // R6: paired reads, last one short
    op(1, 0, 1, 4'h3, 0, 0, 0, 0, 0);
    op(1, 0, 1, 4'hF, 0, 0, 0, 0, 0);
    op(1, 0, 1, 4'hF, 0, 0, 0, 0, 0);
    op(1, 0, 1, 4'hF, 0, 0, 0, 0, 0);
    // R9: fill receive queue to full
    for (int i = 0; i < 66; i++) op(0, 0, 0, 0, 0, 0, 1, 8'($urandom), 3'($urandom));
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] b;
      b = ($urandom % 8 == 0) ? 4'($urandom) : be_set[$urandom % 4];
      op($urandom % 4 != 0, $urandom % 2, $urandom % 3 == 0, b, $urandom,
         $urandom % 3 == 0, $urandom % 2, 8'($urandom), 3'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule